// File: doc/BRIEF.md
# Flash Write-Protect Policy Controller

This block decides whether an on-chip flash array may be changed. It combines three inputs. The first is a hardware write-protect pin. The second is a persistent "protect at boot" flag. The third is a pair of immediate protect flags, one covering the read-only (RO) region and one covering the whole array. From these it grants or refuses the erase and program requests that arrive on a flash command port. Software changes the policy through a small command interface. There are three requests: arm protection for the next boot, protect immediately, and disarm.

A cold-reset pulse models the start of a boot. When it arrives, the block records whether the hardware pin was asserted. If the boot flag is set and the pin is asserted, the block engages RO protection. If the pin is deasserted, the flash stays open but the boot flag is kept. The record of the pin state at the last cold reset decides whether a later disarm request is accepted.

The block publishes a six-bit flag word and a mask of the flags a command could still change. It also publishes a status byte with a lock bit and the start and length of the protected range, so that software can see the policy in force.

Top module: `wp_policy_ctrl`

## Requirements
- R1: After `rst`, the three flags that software can change (boot, RO-now, all-now) are clear. The status byte is 0x00, the range start and length are 0, and a flash request at any address is granted.
- R2: The flag word uses these bit positions: bit0 is the live hardware pin, bit1 is RO-at-boot, bit2 is RO-now, bit3 is all-now, bit4 is stuck (always 0 here) and bit5 is inconsistent. Bits 0, 4 and 5 are never writable, so `writable_o` bits 0, 4 and 5 are always 0.
- R3: A command with op 2'b01 (arm at boot) sets only bit1 and never reports an error. It does not protect any address immediately.
- R4: A command with op 2'b10 (protect now) sets bits 1, 2 and 3 when the pin is asserted. When the pin is deasserted it reports an error and leaves bits 1 to 3 unchanged. Bits 2 and 3 become set only in a cycle that follows one in which the pin was asserted.
- R5: A command with op 2'b11 (disarm) clears bit1 without error only if the pin was deasserted at the most recent cold reset, or if no cold reset has occurred since `rst`. Otherwise it reports an error and bit1 stays set. Bits 2 and 3 are not touched by this command.
- R6: A cold reset sets RO-now to (boot AND pin) and clears all-now, and it keeps the boot flag. Once RO-now and all-now are set, they stay set when the pin later drops, until the next cold reset.
- R7: While all-now is set, every flash request is refused. While only RO-now is set, a request is refused when its address is below `RO_LEN` and granted otherwise. Each request gets exactly one of grant or deny, in the same cycle it is presented.
- R8: The status byte is 0x80 when the boot flag or RO-now is set, and 0x00 otherwise. The range start is always 0. The range length is `RO_LEN` (default 0x1F800) while RO-now is set, and 0 otherwise, including when the boot flag is set but the last cold reset saw the pin deasserted.
- R9: `writable_o` is combinational from the current state. Bit1 is NOT(boot AND pin-at-last-cold-reset). Bit2 is (pin AND NOT RO-now). Bit3 is (pin AND NOT all-now). This gives 0x00 after protect-now following a cold reset with the pin asserted.
- R10: A command answers with `cmd_done`, together with `cmd_err` when it fails, one cycle after it is presented. A command presented in the same cycle as `cold_rst` is discarded: it produces no `cmd_done` and has no effect.
- R11: The inconsistent bit reports a cold reset that should have engaged RO protection (boot and pin both set) while RO-now is clear. In any command sequence the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all policy state |
| hw_wp_in | input | 1 | Hardware write-protect pin, already synchronous |
| cold_rst | input | 1 | One-cycle pulse marking a cold reset (boot) |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 no-op, 01 arm at boot, 10 protect now, 11 disarm |
| cmd_done | output | 1 | Command completed (one cycle after `cmd_valid`) |
| cmd_err | output | 1 | Completed command was refused |
| fl_valid | input | 1 | Erase or program request present |
| fl_addr | input | ADDR_W | Target address of the request |
| fl_grant | output | 1 | Request allowed |
| fl_deny | output | 1 | Request refused |
| flags_o | output | 6 | Flag word |
| writable_o | output | 6 | Flags a command could change now |
| ro_prot_o | output | 1 | RO region protected |
| all_prot_o | output | 1 | Whole array protected |
| status_o | output | 8 | Status byte, lock in bit 7 |
| range_start_o | output | ADDR_W | Protected range start |
| range_len_o | output | ADDR_W | Protected range length |

## Verification
The state stored in the block is small: the boot flag, the two immediate flags and the pin level recorded at the last cold reset. Any error in it shows at the ports without delay. A wrong immediate flag changes `flags_o`, the range length and the grant for an RO address in the same cycle. A wrong recorded pin level stays hidden until a disarm request is made, and then it shows one cycle later as a `cmd_err` that does not match the expected result. It also shows at once in `writable_o` bit1. For this reason the bench follows each cold reset with both a disarm attempt and a read of the mask.

// File: rtl/wp_policy_pkg.sv
package wp_policy_pkg;

    localparam int FLAG_W   = 6;
    localparam int FB_PIN   = 0;
    localparam int FB_BOOT  = 1;
    localparam int FB_RO    = 2;
    localparam int FB_ALL   = 3;
    localparam int FB_STUCK = 4;
    localparam int FB_INCON = 5;
    localparam int LOCK_BIT = 7;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_ARM     = 2'b01,
        CMD_NOW     = 2'b10,
        CMD_DISARM  = 2'b11
    } wp_cmd_e;

    typedef struct packed {
        logic boot;       // persistent protect-at-boot
        logic ro_now;     // RO region locked now
        logic all_now;    // whole array locked now
        logic boot_pin;   // pin level seen at last cold reset
        logic expect_ro;  // cold reset asked for RO lock
    } wp_state_t;

    function automatic logic [FLAG_W-1:0] pack_flags(input wp_state_t s, input logic pin);
        logic [FLAG_W-1:0] f;
        f           = '0;
        f[FB_PIN]   = pin;
        f[FB_BOOT]  = s.boot;
        f[FB_RO]    = s.ro_now;
        f[FB_ALL]   = s.all_now;
        f[FB_STUCK] = 1'b0;
        f[FB_INCON] = s.expect_ro & ~s.ro_now;
        return f;
    endfunction

endpackage

// File: rtl/wp_flag_state.sv
module wp_flag_state
    import wp_policy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hw_wp,
    input  logic      cold_rst,
    input  logic      cmd_valid,
    input  wp_cmd_e   cmd_op,
    output wp_state_t state,
    output logic      cmd_done,
    output logic      cmd_err
);

    wp_state_t nxt;
    logic      nxt_done;
    logic      nxt_err;

    always_comb begin
        nxt      = state;
        nxt_done = 1'b0;
        nxt_err  = 1'b0;
        if (cold_rst) begin
            nxt.boot_pin  = hw_wp;
            nxt.ro_now    = state.boot & hw_wp;
            nxt.all_now   = 1'b0;
            nxt.expect_ro = state.boot & hw_wp;
        end else if (cmd_valid) begin
            nxt_done = 1'b1;
            unique case (cmd_op)
                CMD_NOP: ;
                CMD_ARM: nxt.boot = 1'b1;
                CMD_NOW: begin
                    if (hw_wp) begin
                        nxt.boot    = 1'b1;
                        nxt.ro_now  = 1'b1;
                        nxt.all_now = 1'b1;
                    end else begin
                        nxt_err = 1'b1;
                    end
                end
                CMD_DISARM: begin
                    if (state.boot_pin) nxt_err = 1'b1;
                    else                nxt.boot = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= '0;
            cmd_done <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            state    <= nxt;
            cmd_done <= nxt_done;
            cmd_err  <= nxt_err;
        end
    end

endmodule

// File: rtl/wp_access_gate.sv
module wp_access_gate #(
    parameter int          ADDR_W = 32,
    parameter int unsigned RO_LEN = 32'h0001_F800
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ro_now,
    input  logic              all_now,
    output logic              grant,
    output logic              deny
);

    localparam logic [ADDR_W-1:0] RO_END = ADDR_W'(RO_LEN);

    logic in_ro;
    logic blocked;

    always_comb begin
        in_ro   = (req_addr < RO_END);
        blocked = all_now | (ro_now & in_ro);
        grant   = req_valid & ~blocked;
        deny    = req_valid &  blocked;
    end

endmodule

// File: rtl/wp_status_view.sv
module wp_status_view
    import wp_policy_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int unsigned RO_LEN = 32'h0001_F800
) (
    input  wp_state_t          state,
    input  logic               hw_wp,
    output logic [FLAG_W-1:0]  flags,
    output logic [FLAG_W-1:0]  writable,
    output logic               ro_prot,
    output logic               all_prot,
    output logic [7:0]         status,
    output logic [ADDR_W-1:0]  range_start,
    output logic [ADDR_W-1:0]  range_len
);

    always_comb begin
        flags              = pack_flags(state, hw_wp);
        writable           = '0;
        writable[FB_BOOT]  = ~(state.boot & state.boot_pin);
        writable[FB_RO]    = hw_wp & ~state.ro_now;
        writable[FB_ALL]   = hw_wp & ~state.all_now;
        ro_prot            = state.ro_now | state.all_now;
        all_prot           = state.all_now;
        status             = '0;
        status[LOCK_BIT]   = state.boot | state.ro_now;
        range_start        = '0;
        range_len          = state.ro_now ? ADDR_W'(RO_LEN) : '0;
    end

endmodule

// File: rtl/wp_policy_ctrl.sv
module wp_policy_ctrl
    import wp_policy_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int unsigned RO_LEN = 32'h0001_F800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_wp_in,
    input  logic              cold_rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_done,
    output logic              cmd_err,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_addr,
    output logic              fl_grant,
    output logic              fl_deny,
    output logic [5:0]        flags_o,
    output logic [5:0]        writable_o,
    output logic              ro_prot_o,
    output logic              all_prot_o,
    output logic [7:0]        status_o,
    output logic [ADDR_W-1:0] range_start_o,
    output logic [ADDR_W-1:0] range_len_o
);

    wp_state_t st;

    wp_flag_state u_state (
        .clk       (clk),
        .rst       (rst),
        .hw_wp     (hw_wp_in),
        .cold_rst  (cold_rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (wp_cmd_e'(cmd_op)),
        .state     (st),
        .cmd_done  (cmd_done),
        .cmd_err   (cmd_err)
    );

    wp_access_gate #(.ADDR_W(ADDR_W), .RO_LEN(RO_LEN)) u_gate (
        .req_valid (fl_valid),
        .req_addr  (fl_addr),
        .ro_now    (st.ro_now),
        .all_now   (st.all_now),
        .grant     (fl_grant),
        .deny      (fl_deny)
    );

    wp_status_view #(.ADDR_W(ADDR_W), .RO_LEN(RO_LEN)) u_view (
        .state       (st),
        .hw_wp       (hw_wp_in),
        .flags       (flags_o),
        .writable    (writable_o),
        .ro_prot     (ro_prot_o),
        .all_prot    (all_prot_o),
        .status      (status_o),
        .range_start (range_start_o),
        .range_len   (range_len_o)
    );

endmodule

// File: rtl/wp_policy_checker.sv
module wp_policy_checker #(
    parameter int          ADDR_W = 32,
    parameter int unsigned RO_LEN = 32'h0001_F800
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_wp_in,
    input logic              cold_rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_done,
    input logic              cmd_err,
    input logic              fl_valid,
    input logic              fl_grant,
    input logic              fl_deny,
    input logic [5:0]        flags_o,
    input logic [5:0]        writable_o,
    input logic [7:0]        status_o,
    input logic [ADDR_W-1:0] range_len_o
);

    p_fixed_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (writable_o[0] == 1'b0 && writable_o[5:4] == 2'b00));

    p_now_needs_pin_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cold_rst && cmd_op == 2'b10 && !hw_wp_in)
        |=> (cmd_err && $stable(flags_o[3:1])));

    p_ro_rise_pin_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[2]) |-> $past(hw_wp_in));

    p_boot_clear_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_o[1]) |-> $past(cmd_valid && !cold_rst && cmd_op == 2'b11));

    p_cold_drops_all_r6: assert property (@(posedge clk) disable iff (rst)
        cold_rst |=> !flags_o[3]);

    p_all_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        flags_o[3] |-> !fl_grant);

    p_one_answer_r7: assert property (@(posedge clk) disable iff (rst)
        fl_valid |-> (fl_grant != fl_deny));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !fl_valid |-> (!fl_grant && !fl_deny));

    p_ro_window_r8: assert property (@(posedge clk) disable iff (rst)
        flags_o[2] |-> (status_o == 8'h80 && range_len_o == ADDR_W'(RO_LEN)));

    p_reply_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cold_rst) |=> cmd_done);

    p_drop_on_cold_r10: assert property (@(posedge clk) disable iff (rst)
        cold_rst |=> !cmd_done);

    p_no_incon_r11: assert property (@(posedge clk) disable iff (rst)
        !flags_o[5]);

endmodule

bind wp_policy_ctrl wp_policy_checker #(.ADDR_W(ADDR_W), .RO_LEN(RO_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hw_wp_in    (hw_wp_in),
    .cold_rst    (cold_rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_done    (cmd_done),
    .cmd_err     (cmd_err),
    .fl_valid    (fl_valid),
    .fl_grant    (fl_grant),
    .fl_deny     (fl_deny),
    .flags_o     (flags_o),
    .writable_o  (writable_o),
    .status_o    (status_o),
    .range_len_o (range_len_o)
);

// File: tb/wp_policy_ctrl_test.sv
module wp_policy_ctrl_test;

    localparam int ADDR_W = 32;
    localparam logic [31:0] ROL = 32'h0001_F800;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hw_wp_in = 1'b0;
    logic              cold_rst = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic              cmd_done, cmd_err;
    logic              fl_valid = 1'b0;
    logic [ADDR_W-1:0] fl_addr = '0;
    logic              fl_grant, fl_deny;
    logic [5:0]        flags_o, writable_o;
    logic              ro_prot_o, all_prot_o;
    logic [7:0]        status_o;
    logic [ADDR_W-1:0] range_start_o, range_len_o;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    wp_policy_ctrl uut (
        .clk(clk), .rst(rst), .hw_wp_in(hw_wp_in), .cold_rst(cold_rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_grant(fl_grant), .fl_deny(fl_deny),
        .flags_o(flags_o), .writable_o(writable_o), .ro_prot_o(ro_prot_o),
        .all_prot_o(all_prot_o), .status_o(status_o), .range_start_o(range_start_o),
        .range_len_o(range_len_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // command: returns {done, err} sampled one cycle after presentation
    task automatic do_cmd(input logic [1:0] op, output logic [1:0] resp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        resp = {cmd_done, cmd_err};
    endtask

    task automatic do_cold(input logic with_cmd);
        @(negedge clk);
        cold_rst = 1'b1;
        if (with_cmd) begin cmd_valid = 1'b1; cmd_op = 2'b11; end
        @(negedge clk);
        cold_rst = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic probe(input logic [31:0] addr, output logic [1:0] gd);
        fl_valid = 1'b1; fl_addr = addr;
        #1;
        gd = {fl_grant, fl_deny};
        fl_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [1:0] gd;
        check("R1", "flags", {26'b0, flags_o}, 32'h00);
        check("R1", "status", {24'b0, status_o}, 32'h00);
        check("R1", "range_len", range_len_o, 32'h0);
        check("R1", "range_start", range_start_o, 32'h0);
        probe(32'h0, gd);
        check("R1", "grant at 0", {30'b0, gd}, 32'h2);
        check("R9", "writable pin low", {26'b0, writable_o}, 32'h02);
    endtask

    task automatic t_pin_bit();
        hw_wp_in = 1'b1; #1;
        check("R2", "pin bit live", {26'b0, flags_o}, 32'h01);
        check("R9", "writable pin high", {26'b0, writable_o}, 32'h0E);
        hw_wp_in = 1'b0; #1;
        check("R2", "pin bit low", {26'b0, flags_o}, 32'h00);
    endtask

    task automatic t_arm_and_fail_now();
        logic [1:0] r, gd;
        do_cmd(2'b01, r);
        check("R3", "arm resp", {30'b0, r}, 32'h2);
        check("R3", "arm flags", {26'b0, flags_o}, 32'h02);
        check("R8", "armed status", {24'b0, status_o}, 32'h80);
        check("R8", "armed len", range_len_o, 32'h0);
        probe(32'h10, gd);
        check("R3", "no immediate lock", {30'b0, gd}, 32'h2);
        do_cmd(2'b10, r);
        check("R4", "now w/o pin resp", {30'b0, r}, 32'h3);
        check("R4", "now w/o pin flags", {26'b0, flags_o}, 32'h02);
        do_cmd(2'b11, r);
        check("R5", "disarm after rst", {30'b0, r}, 32'h2);
        check("R5", "disarm flags", {26'b0, flags_o}, 32'h00);
        check("R8", "disarmed status", {24'b0, status_o}, 32'h00);
    endtask

    task automatic t_cold_with_pin();
        logic [1:0] r, gd;
        do_cmd(2'b01, r);
        hw_wp_in = 1'b1;
        do_cold(1'b0);
        check("R6", "cold w/ pin flags", {26'b0, flags_o}, 32'h07);
        check("R8", "locked status", {24'b0, status_o}, 32'h80);
        check("R8", "locked len", range_len_o, ROL);
        check("R9", "writable after pinned boot", {26'b0, writable_o}, 32'h08);
        probe(32'h100, gd);
        check("R7", "RO addr denied", {30'b0, gd}, 32'h1);
        probe(ROL - 1, gd);
        check("R7", "RO last addr denied", {30'b0, gd}, 32'h1);
        probe(ROL, gd);
        check("R7", "RW first addr granted", {30'b0, gd}, 32'h2);
        do_cmd(2'b11, r);
        check("R5", "disarm refused", {30'b0, r}, 32'h3);
        check("R5", "flags kept", {26'b0, flags_o}, 32'h07);
        hw_wp_in = 1'b0; #1;
        check("R6", "latched after pin drop", {26'b0, flags_o}, 32'h06);
        check("R9", "writable pin dropped", {26'b0, writable_o}, 32'h00);
    endtask

    task automatic t_cold_without_pin();
        logic [1:0] r, gd;
        do_cold(1'b0);
        check("R6", "cold w/o pin flags", {26'b0, flags_o}, 32'h02);
        check("R8", "unlocked but armed status", {24'b0, status_o}, 32'h80);
        check("R8", "unlocked len", range_len_o, 32'h0);
        probe(32'h0, gd);
        check("R6", "open after pinless boot", {30'b0, gd}, 32'h2);
        hw_wp_in = 1'b1;
        do_cmd(2'b10, r);
        check("R4", "now with pin resp", {30'b0, r}, 32'h2);
        check("R4", "now with pin flags", {26'b0, flags_o}, 32'h0F);
        check("R9", "writable boot bit free", {26'b0, writable_o}, 32'h02);
        probe(32'h0003_0000, gd);
        check("R7", "RW denied under all-now", {30'b0, gd}, 32'h1);
        check("R7", "all_prot", {31'b0, all_prot_o}, 32'h1);
        do_cold(1'b0);
        check("R6", "cold clears all-now", {26'b0, flags_o}, 32'h07);
        do_cmd(2'b10, r);
        check("R9", "writable fully locked", {26'b0, writable_o}, 32'h00);
        check("R11", "no inconsistent", {31'b0, flags_o[5]}, 32'h0);
    endtask

    task automatic t_cmd_vs_cold();
        logic [1:0] r;
        hw_wp_in = 1'b0;
        do_cold(1'b1);
        check("R10", "dropped cmd no done", {31'b0, cmd_done}, 32'h0);
        check("R10", "dropped disarm no effect", {26'b0, flags_o}, 32'h02);
        do_cmd(2'b00, r);
        check("R10", "nop resp", {30'b0, r}, 32'h2);
        do_cmd(2'b11, r);
        check("R5", "disarm after pinless boot", {30'b0, r}, 32'h2);
        check("R5", "disarm clears boot", {26'b0, flags_o}, 32'h00);
        check("R11", "no inconsistent end", {31'b0, flags_o[5]}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pin_bit();
        t_arm_and_fail_now();
        t_cold_with_pin();
        t_cold_without_pin();
        t_cmd_vs_cold();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule